// File: doc/BRIEF.md
# MDIO Management Master with Register Interface

This block drives a Clause 22 MDIO management bus for a set of PHYs on behalf of software. Software configures the clock prescaler, writes one packed command word naming the PHY, the PHY register, the operation and (for writes) the value, and then polls a status register. The block generates MDC from the system clock, serialises the whole management frame on MDIO, releases the line during a read so that the PHY can answer, and stores the 16 returned bits together with two error flags in a data register.

A single holding stage lets software queue one command while a frame is still on the wire. A command written while the holding stage is occupied is dropped, so software is expected to watch the pending flag before each new command and the busy flag before using read data.

The register interface is a simple synchronous write strobe with a combinational read path selected by a byte address. MDIO is presented as an output value, an output enable and an input, for a tristate pad outside the block.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the status (offset 0x0), data (offset 0xC) and unused offsets read 0, configuration (offset 0x10) reads the prescaler reset value 4 in bits 7:0, MDC is low, MDIO output enable is low and MDIO output is high.
- R2: A configuration write whose bits 7:0 equal 0 leaves the prescaler unchanged; a nonzero value replaces it and reads back in bits 7:0.
- R3: MDC runs continuously with a period of 2×(N+1) system clocks, where N is the prescaler.
- R4: A write to offset 0x8 is taken as a command only when bit 31 (valid) is set and bit 2 (read) or bit 1 (write) is set; bits 29:25 carry the PHY address, bits 24:20 the register address and bits 19:4 the write data. Taking a command sets status bit 2 (pending).
- R5: A command written while pending is set is dropped: the command register keeps the earlier command and no extra frame appears.
- R6: The held command moves to the frame engine as soon as no frame is running; pending and the readback valid bit (bit 31 of offset 0x8) then clear, and status bit 3 (busy) is set from the moment a command is taken until its frame ends.
- R7: Every frame carries 32 ones, start 01, opcode 10 for read or 01 for write, PHY address and register address MSB first; a write continues with turnaround 10 and the 16 data bits MSB first, all with output enable high.
- R8: MDIO output value and output enable change only on a system clock edge at which MDC falls.
- R9: On a read, output enable drops from the first turnaround bit to the end of the frame, and the 16 bits sampled on the MDC rising edges after turnaround appear MSB first in data register bits 15:0.
- R10: Data register bit 16 is set when the PHY leaves the second turnaround bit high and bit 17 when the line is low during the first turnaround bit; the data register changes only at the end of a read frame.
- R11: After a frame ends, MDIO output enable is low and MDIO output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | Access is a write when high |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value to the pad |
| mdio_oe | output | 1 | MDIO pad output enable |
| mdio_i | input | 1 | MDIO value from the pad |

## Verification
The bound checker watches on every cycle that MDIO value and enable move only when MDC falls, that the prescaler never holds 0, that pending rises only after a command write, that the engine starts only out of the holding stage, and that the pad is driven only inside a frame. The full bit order of each frame, the MDC period for a given prescaler, the dropping of a command written while one is queued, and the placement of sampled data and error flags can only be shown by the bench's scenarios, which play the PHY side and compare the captured frames with frames it builds itself.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

    localparam int unsigned BUS_AW   = 5;
    localparam int unsigned BUS_DW   = 32;
    localparam int unsigned PHY_AW   = 5;
    localparam int unsigned PREG_AW  = 5;
    localparam int unsigned MGMT_DW  = 16;
    localparam int unsigned ERR_W    = 2;
    // frame body after the preamble: start, op, phy, reg, turnaround, data
    localparam int unsigned BODY_W   = 2 + 2 + PHY_AW + PREG_AW + 2 + MGMT_DW;

    localparam logic [BUS_AW-1:0] OFS_STATUS = 5'h00;
    localparam logic [BUS_AW-1:0] OFS_CMD    = 5'h08;
    localparam logic [BUS_AW-1:0] OFS_DATA   = 5'h0C;
    localparam logic [BUS_AW-1:0] OFS_CFG    = 5'h10;

    localparam int unsigned CMD_VLD_BIT = 31;
    localparam int unsigned CMD_RD_BIT  = 2;
    localparam int unsigned CMD_WR_BIT  = 1;
    localparam int unsigned ST_PEND_BIT = 2;
    localparam int unsigned ST_BUSY_BIT = 3;

    typedef struct packed {
        logic               is_read;
        logic [PHY_AW-1:0]  phy;
        logic [PREG_AW-1:0] regad;
        logic [MGMT_DW-1:0] wdata;
    } mdm_cmd_t;

    typedef struct packed {
        logic [ERR_W-1:0]   err;
        logic [MGMT_DW-1:0] rdval;
    } mdm_result_t;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_ARM,
        ENG_SHIFT
    } eng_state_e;

    function automatic mdm_cmd_t unpack_cmd(input logic [BUS_DW-1:0] w);
        mdm_cmd_t c;
        c.is_read = w[CMD_RD_BIT];
        c.phy     = w[29:25];
        c.regad   = w[24:20];
        c.wdata   = w[19:4];
        return c;
    endfunction

    function automatic logic [BUS_DW-1:0] pack_cmd(input mdm_cmd_t c, input logic vld);
        logic [BUS_DW-1:0] w;
        w              = '0;
        w[CMD_VLD_BIT] = vld;
        w[29:25]       = c.phy;
        w[24:20]       = c.regad;
        w[19:4]        = c.wdata;
        w[CMD_RD_BIT]  = c.is_read;
        w[CMD_WR_BIT]  = ~c.is_read;
        return w;
    endfunction

    function automatic logic [BODY_W-1:0] frame_body(input mdm_cmd_t c);
        return {2'b01,
                c.is_read ? 2'b10 : 2'b01,
                c.phy,
                c.regad,
                c.is_read ? 2'b11 : 2'b10,
                c.is_read ? {MGMT_DW{1'b1}} : c.wdata};
    endfunction

endpackage

// File: rtl/mdm_clkdiv.sv
module mdm_clkdiv #(
    parameter int unsigned PRESC_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PRESC_W-1:0] presc,
    output logic               mdc,
    output logic               rise_stb,
    output logic               fall_stb
);
    logic [PRESC_W-1:0] cnt_q;
    logic               mdc_q;
    logic               tick;

    // a shrunken prescaler must not strand the counter above it
    assign tick = (cnt_q >= presc);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign mdc      = mdc_q;
    assign rise_stb = tick & ~mdc_q;
    assign fall_stb = tick & mdc_q;

endmodule

// File: rtl/mdm_shifter.sv
module mdm_shifter
    import mdm_pkg::*;
#(
    parameter int unsigned PRE_LEN = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  mdm_cmd_t    cmd,
    input  logic        rise_stb,
    input  logic        fall_stb,
    input  logic        mdio_i,
    output logic        busy,
    output logic        rd_done,
    output mdm_result_t result,
    output logic        mdio_o,
    output logic        mdio_oe
);
    localparam int unsigned FRAME_W = PRE_LEN + BODY_W;
    localparam int unsigned IDX_W   = $clog2(FRAME_W);
    localparam int unsigned TA_IDX  = PRE_LEN + 2 + 2 + PHY_AW + PREG_AW;
    localparam logic [IDX_W-1:0] TA1_I   = IDX_W'(TA_IDX);
    localparam logic [IDX_W-1:0] TA2_I   = IDX_W'(TA_IDX + 1);
    localparam logic [IDX_W-1:0] DATA_I  = IDX_W'(TA_IDX + 2);
    localparam logic [IDX_W-1:0] PRE_TA  = IDX_W'(TA_IDX - 1);
    localparam logic [IDX_W-1:0] LAST_I  = IDX_W'(FRAME_W - 1);

    eng_state_e          st_q;
    logic [FRAME_W-1:0]  sh_q;
    logic [IDX_W-1:0]    idx_q;
    logic                rd_q;
    logic [MGMT_DW-1:0]  cap_q;
    logic [ERR_W-1:0]    err_q;
    logic                o_q;
    logic                oe_q;
    logic                done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ENG_IDLE;
            sh_q   <= '0;
            idx_q  <= '0;
            rd_q   <= 1'b0;
            cap_q  <= '0;
            err_q  <= '0;
            o_q    <= 1'b1;
            oe_q   <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                ENG_IDLE: begin
                    if (start) begin
                        sh_q  <= {{PRE_LEN{1'b1}}, frame_body(cmd)};
                        rd_q  <= cmd.is_read;
                        idx_q <= '0;
                        err_q <= '0;
                        cap_q <= '0;
                        st_q  <= ENG_ARM;
                    end
                end
                ENG_ARM: begin
                    if (fall_stb) begin
                        o_q  <= sh_q[FRAME_W-1];
                        oe_q <= 1'b1;
                        sh_q <= {sh_q[FRAME_W-2:0], 1'b0};
                        st_q <= ENG_SHIFT;
                    end
                end
                ENG_SHIFT: begin
                    if (rise_stb && rd_q) begin
                        if (idx_q == TA1_I) err_q[1] <= ~mdio_i;
                        if (idx_q == TA2_I) err_q[0] <= mdio_i;
                        if (idx_q >= DATA_I) cap_q <= {cap_q[MGMT_DW-2:0], mdio_i};
                    end
                    if (fall_stb) begin
                        if (idx_q == LAST_I) begin
                            st_q   <= ENG_IDLE;
                            o_q    <= 1'b1;
                            oe_q   <= 1'b0;
                            done_q <= rd_q;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                            o_q   <= sh_q[FRAME_W-1];
                            sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
                            oe_q  <= ~(rd_q && (idx_q >= PRE_TA));
                        end
                    end
                end
                default: st_q <= ENG_IDLE;
            endcase
        end
    end

    assign busy    = (st_q != ENG_IDLE);
    assign rd_done = done_q;
    assign result  = '{err: err_q, rdval: cap_q};
    assign mdio_o  = o_q;
    assign mdio_oe = oe_q;

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdm_pkg::*;
#(
    parameter int unsigned          PRESC_W     = 8,
    parameter logic [PRESC_W-1:0]   PRESC_RESET = 8'd4,
    parameter int unsigned          PRE_LEN     = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic              mdc_o,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic               pend_q;
    mdm_cmd_t           hold_q;
    logic [PRESC_W-1:0] presc_q;
    mdm_result_t        data_q;

    logic               wr_cmd;
    logic               wr_cfg;
    logic               cmd_ok;
    mdm_cmd_t           in_cmd;
    logic               start;
    logic               eng_busy;
    logic               eng_rd_done;
    mdm_result_t        eng_result;
    logic               rise_stb;
    logic               fall_stb;

    assign wr_cmd = bus_valid && bus_write && (bus_addr == OFS_CMD);
    assign wr_cfg = bus_valid && bus_write && (bus_addr == OFS_CFG);
    assign cmd_ok = bus_wdata[CMD_VLD_BIT] && (bus_wdata[CMD_RD_BIT] || bus_wdata[CMD_WR_BIT]);
    assign in_cmd = unpack_cmd(bus_wdata);
    assign start  = pend_q && !eng_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= 1'b0;
            hold_q  <= '0;
            presc_q <= PRESC_RESET;
            data_q  <= '0;
        end else begin
            if (start) begin
                pend_q <= 1'b0;
            end
            if (wr_cmd && cmd_ok && !pend_q) begin
                pend_q <= 1'b1;
                hold_q <= in_cmd;
            end
            if (wr_cfg && (bus_wdata[PRESC_W-1:0] != '0)) begin
                presc_q <= bus_wdata[PRESC_W-1:0];
            end
            if (eng_rd_done) begin
                data_q <= eng_result;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_STATUS: begin
                bus_rdata[ST_PEND_BIT] = pend_q;
                bus_rdata[ST_BUSY_BIT] = pend_q | eng_busy;
            end
            OFS_CMD:  bus_rdata = pack_cmd(hold_q, pend_q);
            OFS_DATA: bus_rdata[ERR_W+MGMT_DW-1:0] = data_q;
            OFS_CFG:  bus_rdata[PRESC_W-1:0] = presc_q;
            default:  bus_rdata = '0;
        endcase
    end

    mdm_clkdiv #(
        .PRESC_W (PRESC_W)
    ) u_div (
        .clk      (clk),
        .rst      (rst),
        .presc    (presc_q),
        .mdc      (mdc_o),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdm_shifter #(
        .PRE_LEN (PRE_LEN)
    ) u_eng (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cmd      (hold_q),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .mdio_i   (mdio_i),
        .busy     (eng_busy),
        .rd_done  (eng_rd_done),
        .result   (eng_result),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );

endmodule

// File: rtl/mdm_checker.sv
module mdm_checker
    import mdm_pkg::*;
#(
    parameter int unsigned PRESC_W = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_valid,
    input logic               bus_write,
    input logic [BUS_AW-1:0]  bus_addr,
    input logic               mdc_o,
    input logic               mdio_o,
    input logic               mdio_oe,
    input logic               pend,
    input logic               eng_busy,
    input logic [PRESC_W-1:0] presc
);

    assert_mdio_on_fall_R8: assert property (@(posedge clk) disable iff (rst)
        ((mdio_o != $past(mdio_o)) || (mdio_oe != $past(mdio_oe))) |-> ($past(mdc_o) && !mdc_o))
        else $error("MDIO moved without a falling MDC");

    assert_presc_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
        presc != '0)
        else $error("prescaler holds zero");

    assert_pend_from_write_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> $past(bus_valid && bus_write && (bus_addr == OFS_CMD)))
        else $error("pending rose without a command write");

    assert_start_from_hold_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(eng_busy) |-> ($past(pend) && !pend))
        else $error("engine started without a held command");

    assert_drive_in_frame_R11: assert property (@(posedge clk) disable iff (rst)
        mdio_oe |-> eng_busy)
        else $error("MDIO driven outside a frame");

endmodule

bind mdio_mgmt_master mdm_checker #(.PRESC_W(PRESC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .mdc_o     (mdc_o),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .pend      (pend_q),
    .eng_busy  (eng_busy),
    .presc     (presc_q)
);

// File: tb/mdio_mgmt_master_tb.sv
module mdio_mgmt_master_tb;
    localparam int CLK_PERIOD = 10;
    localparam int FRAME_BITS = 64;
    localparam int TA_POS     = 46;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc_o;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_mgmt_master u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .mdc_o     (mdc_o),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // PHY-side model state
    logic        rsp_ta1 = 1'b1;
    logic        rsp_ta2 = 1'b0;
    logic [15:0] rsp_data = '0;
    logic [63:0] obs_o;
    logic [63:0] obs_oe;
    int          rc = 0;
    bit          in_frame = 0;
    int          frames = 0;
    int          per_cnt = 0;
    int          last_period = 0;
    int          edge_viol = 0;
    logic        mdc_prev = 1'b0;
    logic        prev_o = 1'b1;
    logic        prev_oe = 1'b0;
    logic [31:0] exp_data = '0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic phy_bit(input int k);
        if (k == TA_POS)     return rsp_ta1;
        if (k == TA_POS + 1) return rsp_ta2;
        if (k >= TA_POS + 2) return rsp_data[15 - (k - TA_POS - 2)];
        return 1'b1;
    endfunction

    function automatic logic [31:0] mk_cmd(input logic rd, input logic [4:0] phy,
                                          input logic [4:0] rg, input logic [15:0] wd, input logic vld);
        return {vld, 1'b0, phy, rg, wd, 1'b0, rd, ~rd, 1'b0};
    endfunction

    function automatic logic [63:0] exp_frame(input logic rd, input logic [4:0] phy,
                                             input logic [4:0] rg, input logic [15:0] wd);
        return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, rg,
                rd ? 2'b00 : 2'b10, rd ? 16'h0000 : wd};
    endfunction

    // PHY model and line monitor
    always @(negedge clk) begin
        if (rst) begin
            mdc_prev = 1'b0; prev_o = 1'b1; prev_oe = 1'b0;
            in_frame = 0; rc = 0; per_cnt = 0; mdio_i = 1'b1;
        end else begin
            per_cnt++;
            if (mdc_o && !mdc_prev) begin
                last_period = per_cnt;
                per_cnt = 0;
                if (in_frame && rc < FRAME_BITS) begin
                    obs_o[63 - rc]  = mdio_o;
                    obs_oe[63 - rc] = mdio_oe;
                    rc++;
                end
            end
            if (!mdc_o && mdc_prev) begin
                if (in_frame && rc == FRAME_BITS) begin
                    in_frame = 0;
                    frames++;
                    mdio_i = 1'b1;
                end else if (!in_frame && mdio_oe) begin
                    in_frame = 1;
                    rc = 0;
                end
                if (in_frame) mdio_i = phy_bit(rc);
            end else if ((mdio_o !== prev_o) || (mdio_oe !== prev_oe)) begin
                edge_viol++;
            end
            prev_o = mdio_o; prev_oe = mdio_oe; mdc_prev = mdc_o;
        end
    end

    task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_write = 1'b1; bus_valid = 1'b1;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_valid = 1'b1; bus_write = 1'b0;
        #1 d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        s = 32'h8;
        while (s[3]) bus_rd(5'h00, s);
    endtask

    task automatic set_presc(input int n);
        logic [31:0] v;
        bus_wr(5'h10, n);
        bus_rd(5'h10, v);
        check(v == n, "R2 prescaler readback", v, n);
        repeat (6 * (n + 1) + 4) @(negedge clk);
        check(last_period == 2 * (n + 1), "R3 MDC period", last_period, 2 * (n + 1));
    endtask

    task automatic run_cmd(input logic rd, input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] wd, input logic ta1, input logic ta2,
                           input logic [15:0] rdat);
        int f0;
        logic [31:0] v;
        logic [63:0] ef, mask, eoe;
        rsp_ta1 = ta1; rsp_ta2 = ta2; rsp_data = rdat;
        f0 = frames;
        bus_wr(5'h08, mk_cmd(rd, phy, rg, wd, 1'b1));
        wait_idle();
        check(frames == f0 + 1, "R6 one frame per command", frames, f0 + 1);
        ef   = exp_frame(rd, phy, rg, wd);
        mask = rd ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
        eoe  = rd ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
        check((obs_o & mask) == (ef & mask), "R7 frame bits", obs_o & mask, ef & mask);
        check(obs_oe == eoe, rd ? "R9 read output enable" : "R7 write output enable", obs_oe, eoe);
        if (rd) exp_data = {14'h0, ~ta1, ta2, rdat};
        bus_rd(5'h0C, v);
        check(v == exp_data, rd ? "R9 R10 read data and errors" : "R10 data kept on write", v, exp_data);
        check(mdio_oe == 1'b0 && mdio_o == 1'b1, "R11 line released", {mdio_oe, mdio_o}, 2'b01);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        int f0;
        void'($urandom(32'h5EED_1234));
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        bus_rd(5'h00, v); check(v == 0, "R1 status reset", v, 0);
        bus_rd(5'h10, v); check(v == 4, "R1 config reset", v, 4);
        bus_rd(5'h0C, v); check(v == 0, "R1 data reset", v, 0);
        bus_rd(5'h04, v); check(v == 0, "R1 unused offset", v, 0);
        check(mdio_oe == 0 && mdio_o == 1, "R1 line idle", {mdio_oe, mdio_o}, 2'b01);

        // R2 zero prescaler ignored
        bus_wr(5'h10, 32'h0);
        bus_rd(5'h10, v); check(v == 4, "R2 zero write ignored", v, 4);
        set_presc(2);

        // R4 commands lacking valid or op bits are not taken
        f0 = frames;
        bus_wr(5'h08, mk_cmd(1'b1, 5'd3, 5'd2, 16'h0, 1'b0));
        bus_wr(5'h08, 32'h8000_0000);
        bus_rd(5'h00, v); check(v == 0, "R4 incomplete command ignored", v, 0);
        repeat (500) @(negedge clk);
        check(frames == f0, "R4 no frame for incomplete command", frames, f0);

        // directed reads and writes
        run_cmd(1'b1, 5'h1F, 5'h00, 16'h0, 1'b1, 1'b0, 16'hA5C3);
        run_cmd(1'b0, 5'h00, 5'h1F, 16'h8001, 1'b1, 1'b0, 16'h0);
        run_cmd(1'b1, 5'h0A, 5'h15, 16'h0, 1'b1, 1'b1, 16'h0F0F);
        run_cmd(1'b1, 5'h15, 5'h0A, 16'h0, 1'b0, 1'b0, 16'hFFFF);

        // R5 R6 queueing and drop
        rsp_ta1 = 1'b1; rsp_ta2 = 1'b0; rsp_data = 16'h1357;
        f0 = frames;
        bus_wr(5'h08, mk_cmd(1'b0, 5'd1, 5'd2, 16'hBEEF, 1'b1));
        repeat (2) @(negedge clk);
        bus_rd(5'h00, v); check(v == 32'h8, "R6 taken: busy without pending", v, 32'h8);
        bus_wr(5'h08, mk_cmd(1'b1, 5'd3, 5'd4, 16'h0, 1'b1));
        bus_rd(5'h00, v); check(v == 32'hC, "R4 queued: pending and busy", v, 32'hC);
        bus_wr(5'h08, mk_cmd(1'b0, 5'd9, 5'd9, 16'h1111, 1'b1));
        bus_rd(5'h08, v);
        check(v == mk_cmd(1'b1, 5'd3, 5'd4, 16'h0, 1'b1), "R5 held command kept", v,
              mk_cmd(1'b1, 5'd3, 5'd4, 16'h0, 1'b1));
        while (frames < f0 + 2) @(negedge clk);
        wait_idle();
        check((obs_o & {{46{1'b1}}, 18'h0}) == (exp_frame(1'b1, 5'd3, 5'd4, 16'h0) & {{46{1'b1}}, 18'h0}),
              "R5 second frame is the queued read", obs_o, exp_frame(1'b1, 5'd3, 5'd4, 16'h0));
        bus_rd(5'h08, v); check(v[31] == 1'b0, "R6 valid self-cleared", v[31], 0);
        bus_rd(5'h0C, v); check(v == 32'h1357, "R9 queued read data", v, 32'h1357);
        exp_data = 32'h1357;
        repeat (1000) @(negedge clk);
        check(frames == f0 + 2, "R5 dropped command sent no frame", frames, f0 + 2);

        // random mix
        for (int i = 0; i < 20; i++) begin
            logic rd;
            logic bad;
            if (i % 5 == 0) set_presc(1 + ($urandom % 5));
            rd  = $urandom % 2;
            bad = ($urandom % 4) == 0;
            run_cmd(rd, 5'($urandom), 5'($urandom), 16'($urandom),
                    bad ? 1'($urandom) : 1'b1, bad ? 1'($urandom) : 1'b0, 16'($urandom));
        end

        check(edge_viol == 0, "R8 line changes only on falling MDC", edge_viol, 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule